// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns the exact 16-bit product. It is intended as the multiplier core of an arithmetic datapath, for example inside a filter tap. All 64 partial-product bits are formed at once with AND gates and arranged as eight shifted rows. The rows are then reduced to two rows in carry-save form, and a carry-lookahead adder turns those two rows into the binary product.

The reduction has two stages. In stage 1, the five lowest rows go through a row of 5:2 compressors, one per column. At the same time, the three upper rows go through a row of full adders. Stage 1 leaves four rows. In stage 2, a row of 4:2 compressors reduces those four rows to two. Inside each compressor row, the lateral carries pass from each column to the next higher column. The lateral carries into column 0 are tied to 0. Each compressor computes its lateral carries without using its own carry-ins, so a carry never ripples along a compressor row.

Terms of weight 2^16 that leave the top column are discarded. Discarding them is exact because the true product is always below 2^16. The cells use an XOR/XNOR-plus-multiplexer style: the first XOR of a pair selects between an input and its inverse, in place of a second XOR gate. When `OUT_REG` is 1 (the default), the product is registered and appears one cycle after the operands. When `OUT_REG` is 0, the product is purely combinational. The block has no states: its only sequential element is the optional output register.

Top module: `wt_mult`

## Requirements
- R1: With `OUT_REG`=1, `prod` after a rising edge equals `opa*opb` (unsigned, 16 bits) as sampled at that edge, for all 65536 operand pairs.
- R2: While `rst_n` is low, `prod` is 0 (asynchronous clear), whatever the operands are.
- R3: Stage 1 maps rows 0..4 through 5:2 compressors and rows 5..7 through full adders. The four resulting rows, plus 2^16 times the count of discarded top-column carries, equal `opa*opb` exactly.
- R4: Stage 2 (4:2 compressors) maps the four stage-1 rows to two rows. Those two rows, plus 2^16 times the count of discarded carries, equal the sum of the four stage-1 rows exactly.
- R5: The 5:2 cell satisfies x1+x2+x3+x4+x5+cin1+cin2 = sum + 2*(carry+cout1+cout2) for all 128 input combinations. Its cout1 and cout2 do not depend on cin1 or cin2.
- R6: The 4:2 cell satisfies x1+x2+x3+x4+cin = sum + 2*(carry+cout) for all 32 input combinations. Its cout does not depend on cin.
- R7: The final adder is built from 4-bit lookahead groups and returns x+y modulo 2^16, with a carry-out equal to bit 16 of x+y. This holds for carries that cross every group boundary (for example 0xFFFF+0x0001 gives 0x0000 with carry-out 1).
- R8: A zero operand gives a product of 0, and 0xFF*0xFF gives 0xFE01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous clear of the output register |
| opa | input | 8 | Multiplicand, unsigned |
| opb | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Product, unsigned |

## Verification
Three arithmetic checks run on every clock out of reset. The first is exact value conservation through both reduction stages, with discarded top-column carries counted in. The second is that the final adder's 17-bit result equals the two rows it adds. The third is that the output register holds the previous cycle's product and clears during reset. A compressor's lateral carries must not depend on its carry-ins, but that property and the cell equations over every input combination cannot be seen from the top ports. They can only be shown by the bench's standalone sweeps of each cell. Full operand coverage, including the zero and all-ones corners, likewise comes only from the bench's sweep of all 65536 operand pairs.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;
    localparam int GRP_W  = 4;
    localparam int N_ROWS = OP_W;
endpackage

// File: rtl/wtm_cmp42.sv
// 4:2 compressor cell: x0+x1+x2+x3+cin = sum + 2*(carry+cout)
// cout is formed from x0..x2 only, so it never waits on cin.
module wtm_cmp42 (
    input  logic [3:0] x,
    input  logic       cin,
    output logic       sum,
    output logic       carry,
    output logic       cout
);
    logic t, u, s1;
    always_comb begin
        t     = x[0] ^ x[1];
        u     = x[2] ^ x[3];
        s1    = t ? ~u : u;          // mux in place of second XOR
        cout  = t ? x[2] : x[0];     // majority of x0,x1,x2
        sum   = s1 ? ~cin : cin;
        carry = s1 ? cin : x[3];
    end
endmodule

// File: rtl/wtm_cmp52.sv
// 5:2 compressor cell:
// x0+..+x4+cin1+cin2 = sum + 2*(carry+cout1+cout2)
// cout1 and cout2 come from the primary inputs only.
module wtm_cmp52 (
    input  logic [4:0] x,
    input  logic       cin1,
    input  logic       cin2,
    output logic       sum,
    output logic       carry,
    output logic       cout1,
    output logic       cout2
);
    logic t, sa, w, sb, q;
    always_comb begin
        t     = x[0] ^ x[1];
        sa    = t ? ~x[2] : x[2];
        cout1 = t ? x[2] : x[0];
        w     = sa ^ x[3];
        sb    = w ? ~x[4] : x[4];
        cout2 = w ? x[4] : sa;
        q     = cin1 ^ cin2;
        sum   = sb ? ~q : q;
        carry = q ? sb : cin1;
    end
endmodule

// File: rtl/wtm_red_row.sv
// One reduction row across all columns. NIN picks the cell:
// 5 -> 5:2 compressors, 4 -> 4:2 compressors, 3 -> full adders.
// spill counts the weight-2^W terms leaving the top column.
module wtm_red_row #(
    parameter int W   = 16,
    parameter int NIN = 5
) (
    input  logic [NIN-1:0][W-1:0] rows,
    output logic [W-1:0]          sum_row,
    output logic [W-1:0]          car_row,
    output logic [1:0]            spill
);
    logic [W-1:0] car_w;

    assign car_row = {car_w[W-2:0], 1'b0};

    if (NIN == 5) begin : g_c52
        logic [W:0] ch1, ch2;
        assign ch1[0] = 1'b0;
        assign ch2[0] = 1'b0;
        for (genvar c = 0; c < W; c++) begin : g_col
            logic [4:0] cx;
            for (genvar k = 0; k < 5; k++) begin : g_bit
                assign cx[k] = rows[k][c];
            end
            wtm_cmp52 u_cell (
                .x(cx), .cin1(ch1[c]), .cin2(ch2[c]),
                .sum(sum_row[c]), .carry(car_w[c]),
                .cout1(ch1[c+1]), .cout2(ch2[c+1])
            );
        end
        assign spill = 2'(car_w[W-1]) + 2'(ch1[W]) + 2'(ch2[W]);
    end else if (NIN == 4) begin : g_c42
        logic [W:0] ch;
        assign ch[0] = 1'b0;
        for (genvar c = 0; c < W; c++) begin : g_col
            logic [3:0] cx;
            for (genvar k = 0; k < 4; k++) begin : g_bit
                assign cx[k] = rows[k][c];
            end
            wtm_cmp42 u_cell (
                .x(cx), .cin(ch[c]),
                .sum(sum_row[c]), .carry(car_w[c]), .cout(ch[c+1])
            );
        end
        assign spill = 2'(car_w[W-1]) + 2'(ch[W]);
    end else begin : g_fa
        for (genvar c = 0; c < W; c++) begin : g_col
            logic a0, a1, a2;
            assign a0 = rows[0][c];
            assign a1 = rows[1][c];
            assign a2 = rows[2][c];
            assign sum_row[c] = (a0 ^ a1) ? ~a2 : a2;
            assign car_w[c]   = (a0 ^ a1) ? a2 : a0;
        end
        assign spill = {1'b0, car_w[W-1]};
    end
endmodule

// File: rtl/wtm_cla.sv
// Two-level carry-lookahead adder: bit generate/propagate,
// group generate/propagate per GRP bits, group carries from those.
module wtm_cla #(
    parameter int W   = 16,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int NG = W / GRP;

    logic [W-1:0] g, pr;
    assign g  = x & y;
    assign pr = x ^ y;

    always_comb begin
        logic [NG-1:0] grp_g, grp_p;
        logic [NG:0]   gc;
        logic [W-1:0]  c;
        for (int m = 0; m < NG; m++) begin
            grp_g[m] = 1'b0;
            grp_p[m] = 1'b1;
            for (int k = 0; k < GRP; k++) begin
                grp_g[m] = g[m*GRP+k] | (pr[m*GRP+k] & grp_g[m]);
                grp_p[m] = grp_p[m] & pr[m*GRP+k];
            end
        end
        gc[0] = 1'b0;
        for (int m = 0; m < NG; m++) begin
            gc[m+1] = grp_g[m] | (grp_p[m] & gc[m]);
        end
        for (int m = 0; m < NG; m++) begin
            c[m*GRP] = gc[m];
            for (int k = 1; k < GRP; k++) begin
                c[m*GRP+k] = g[m*GRP+k-1] | (pr[m*GRP+k-1] & c[m*GRP+k-1]);
            end
        end
        s  = pr ^ c;
        co = gc[NG];
    end
endmodule

// File: rtl/wt_mult.sv
module wt_mult #(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [wtm_pkg::OP_W-1:0]   opa,
    input  logic [wtm_pkg::OP_W-1:0]   opb,
    output logic [wtm_pkg::PROD_W-1:0] prod
);
    import wtm_pkg::*;

    // partial-product rows, row i shifted left by i
    logic [N_ROWS-1:0][PROD_W-1:0] pp;
    for (genvar i = 0; i < N_ROWS; i++) begin : g_pp
        assign pp[i] = PROD_W'(opa & {OP_W{opb[i]}}) << i;
    end

    // stage 1: rows 0..4 via 5:2, rows 5..7 via full adders
    logic [PROD_W-1:0] s5, c5, s3, c3;
    logic [1:0]        spill5, spill3;

    wtm_red_row #(.W(PROD_W), .NIN(5)) u_st1_c52 (
        .rows(pp[4:0]), .sum_row(s5), .car_row(c5), .spill(spill5)
    );
    wtm_red_row #(.W(PROD_W), .NIN(3)) u_st1_fa (
        .rows(pp[7:5]), .sum_row(s3), .car_row(c3), .spill(spill3)
    );

    // stage 2: four rows to two via 4:2
    logic [3:0][PROD_W-1:0] st2_in;
    logic [PROD_W-1:0]      s2, c2;
    logic [1:0]             spill4;
    assign st2_in = {c3, s3, c5, s5};

    wtm_red_row #(.W(PROD_W), .NIN(4)) u_st2_c42 (
        .rows(st2_in), .sum_row(s2), .car_row(c2), .spill(spill4)
    );

    // final carry-propagate adder
    logic [PROD_W-1:0] prod_c;
    logic              fin_co;
    wtm_cla #(.W(PROD_W), .GRP(GRP_W)) u_cla (
        .x(s2), .y(c2), .s(prod_c), .co(fin_co)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod <= '0;
            else        prod <= prod_c;
        end
    end else begin : g_comb
        assign prod = prod_c;
    end
endmodule

// File: rtl/wt_mult_chk.sv
module wt_mult_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  opa,
    input logic [7:0]  opb,
    input logic [15:0] prod,
    input logic [15:0] s5, c5, s3, c3,
    input logic [1:0]  spill5, spill3,
    input logic [15:0] s2, c2,
    input logic [1:0]  spill4,
    input logic [15:0] prod_c,
    input logic        fin_co
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic [31:0] st1_total, st2_total, exact;
    assign exact     = 32'(opa) * 32'(opb);
    assign st1_total = 32'(s5) + 32'(c5) + 32'(s3) + 32'(c3)
                     + ((32'(spill5) + 32'(spill3)) << 16);
    assign st2_total = 32'(s2) + 32'(c2) + (32'(spill4) << 16);

    // R3: stage-1 rows conserve the exact product
    a_r3_stage1_exact: assert property (@(posedge clk) disable iff (!rst_n)
        st1_total == exact);

    // R4: stage-2 rows conserve the stage-1 total
    a_r4_stage2_exact: assert property (@(posedge clk) disable iff (!rst_n)
        st2_total == 32'(s5) + 32'(c5) + 32'(s3) + 32'(c3));

    // R7: adder result with carry-out equals its two inputs
    a_r7_adder_exact: assert property (@(posedge clk) disable iff (!rst_n)
        {fin_co, prod_c} == 17'(s2) + 17'(c2));

    if (OUT_REG) begin : g_reg_chk
        // R1: registered product of last cycle's operands
        a_r1_product_latency: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> prod == 16'($past(opa)) * 16'($past(opb)));

        // R8: zero operand yields zero product
        a_r8_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && ($past(opa) == 8'd0 || $past(opb) == 8'd0)) |-> prod == 16'd0);

        // R2: cleared while reset is held
        always @(posedge clk) begin
            if (!rst_n) begin
                a_r2_reset_clear: assert (prod == 16'd0);
            end
        end
    end else begin : g_comb_chk
        // R1: combinational product
        a_r1_product_comb: assert property (@(posedge clk) disable iff (!rst_n)
            prod == 16'(opa) * 16'(opb));
    end
endmodule

bind wt_mult wt_mult_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .prod(prod),
    .s5(s5), .c5(c5), .s3(s3), .c3(c3),
    .spill5(spill5), .spill3(spill3),
    .s2(s2), .c2(c2), .spill4(spill4),
    .prod_c(prod_c), .fin_co(fin_co)
);

// File: tb/sim_wt_mult.sv
module sim_wt_mult;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opa = 8'd0, opb = 8'd0;
    logic [15:0] prod;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wt_mult u0 (.clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .prod(prod));

    // standalone cells and adder
    logic [4:0] c5x;  logic c5i1, c5i2, c5s, c5c, c5o1, c5o2;
    logic [3:0] c4x;  logic c4i, c4s, c4c, c4o;
    logic [15:0] ax, ay, as_; logic aco;
    wtm_cmp52 u_c52 (.x(c5x), .cin1(c5i1), .cin2(c5i2), .sum(c5s),
                     .carry(c5c), .cout1(c5o1), .cout2(c5o2));
    wtm_cmp42 u_c42 (.x(c4x), .cin(c4i), .sum(c4s), .carry(c4c), .cout(c4o));
    wtm_cla #(.W(16), .GRP(4)) u_add (.x(ax), .y(ay), .s(as_), .co(aco));

    typedef struct packed { logic [7:0] a; logic [7:0] b; logic [15:0] exp; } item_t;
    item_t sb_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: apply operands and push the expected product
    task automatic drive(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        opa = a;
        opb = b;
        sb_q.push_back('{a: a, b: b, exp: 16'(a) * 16'(b)});
    endtask

    // monitor: one-cycle latency, compare just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.a == 8'd0 || it.b == 8'd0 || (it.a == 8'hFF && it.b == 8'hFF))
                check("R8 corner product", 32'(prod), 32'(it.exp));
            else
                check("R1 product (R3,R4 tree)", 32'(prod), 32'(it.exp));
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit r1_5[32], r2_5[32], r_4[16];

        // R5: 5:2 cell, all 128 combinations, lateral carries cin-independent
        for (int v = 0; v < 128; v++) begin
            c5x = v[4:0]; c5i1 = v[5]; c5i2 = v[6];
            #1;
            check("R5 cmp52 equation",
                  32'(c5s) + 2 * (32'(c5c) + 32'(c5o1) + 32'(c5o2)),
                  32'($countones(v[6:0])));
            if (v < 32) begin
                r1_5[v] = c5o1; r2_5[v] = c5o2;
            end else begin
                check("R5 cmp52 cout independent of cin", {c5o1, c5o2},
                      {r1_5[v % 32], r2_5[v % 32]});
            end
        end

        // R6: 4:2 cell, all 32 combinations, cout cin-independent
        for (int v = 0; v < 32; v++) begin
            c4x = v[3:0]; c4i = v[4];
            #1;
            check("R6 cmp42 equation", 32'(c4s) + 2 * (32'(c4c) + 32'(c4o)),
                  32'($countones(v[4:0])));
            if (v < 16) r_4[v] = c4o;
            else check("R6 cmp42 cout independent of cin", 32'(c4o), 32'(r_4[v % 16]));
        end

        // R7: lookahead adder across group boundaries
        begin
            logic [15:0] xs[5] = '{16'hFFFF, 16'h8000, 16'h1234, 16'h0F0F, 16'h7FFF};
            logic [15:0] ys[5] = '{16'h0001, 16'h8000, 16'h4321, 16'hF0F1, 16'h0001};
            for (int k = 0; k < 5; k++) begin
                ax = xs[k]; ay = ys[k];
                #1;
                check("R7 cla sum+carry", {15'd0, aco, as_}, 32'(17'(xs[k]) + 17'(ys[k])));
            end
        end

        // R2: reset holds output at zero with live operands
        opa = 8'hFF; opb = 8'hFF;
        repeat (3) @(negedge clk);
        check("R2 reset clear", 32'(prod), 32'd0);
        rst_n = 1'b1;

        // R8 corners then R1 exhaustive sweep
        drive(8'hFF, 8'hFF);
        drive(8'h00, 8'hA5);
        drive(8'h5A, 8'h00);
        for (int i = 0; i < 65536; i++) begin
            drive(i[15:8], i[7:0]);
        end
        @(negedge clk);
        @(negedge clk);

        // R2: asynchronous clear mid-run
        rst_n = 1'b0;
        #1;
        check("R2 async clear mid-run", 32'(prod), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'hC3, 8'h3C);
        @(negedge clk);
        @(negedge clk);
        check("R1 empty scoreboard", 32'(sb_q.size()), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule